// File: doc/BRIEF.md
# I2C Master Register and Interrupt Front-End

This block is the processor-facing side of an I2C master controller. It decodes a window of 32 word registers and holds the control word, the serial timing settings, the slave address and the byte-count settings. These settings go to a separate serial protocol engine as plain configuration outputs. Two FIFOs sit between software and the engine and share one data word. A write to that word queues a 9-bit entry for transmission: a command flag and eight data bits. A read of the same word takes the oldest received byte.

The engine reports its progress through single-cycle event inputs and level status inputs. The block turns these into sticky interrupt flags. Software masks the flags with an enable register and clears them by writing ones. The block drives one interrupt line. A reset word lets software flush either FIFO at once, or request a forced controller reset. The request stays visible until the engine acknowledges it.

Top module: `i2cf_regs`

## Requirements
- R1: `bus_addr` is a word index, equal to the byte offset divided by four. These words are read/write and read back at their stored width: control word 0 (4 bits), slave address word 3 (SLVW bits), cycle word 4, low time word 5, restart/stop setup word 6 and data setup word 7 (TIMW bits each), interrupt enable word 9 (interrupt bits only), noise filter word 15 (8 bits), TX byte count word 16 and RX byte count word 17 (CNTW bits each), and bus reset word 20 (2 bits). Each stored value also appears on its `cfg_*` output.
- R2: Words 2 and 12, words 21 to 31, and the clear word 10 read as 0. Writes to words 2, 12 and 21 to 31 change no register.
- R3: A write to word 1 queues bits 8:0 into the TX FIFO, FIFO_DEPTH entries deep. The engine sees the oldest entry on `eng_tx_data`, with `eng_tx_valid` high while the FIFO is not empty, and removes it with `eng_tx_take`. A write to a full TX FIFO is dropped.
- R4: A read of word 1 returns the oldest RX byte in bits 7:0 and removes it. A read of an empty RX FIFO returns 0 and changes nothing. A byte pushed by the engine into a full RX FIFO is dropped.
- R5: Status word 11 shows device busy at bit 12, bus busy at bit 8, RX full at bit 3, RX not empty at bit 2, TX not full at bit 1 and TX empty at bit 0. Word 14 returns `eng_bus_mon`.
- R6: Word 8 holds four sticky interrupt flags: TX drained at bit 9, RX count reached at bit 4, no acknowledge at bit 2 and arbitration lost at bit 1. Writing ones to word 10 clears the matching flags. If a flag is set and cleared in the same cycle, the set wins. Writes to word 8 are ignored.
- R7: `irq_o` is high exactly when some flag of word 8 has its enable bit set in word 9.
- R8: The TX drained flag is set when the TX FIFO changes from non-empty to empty while `eng_active` is high. The same change while `eng_active` is low sets nothing.
- R9: The RX count flag is set on a received byte that brings the RX monitor to the RX byte count. A count of 0 sets the flag on every received byte.
- R10: The TX monitor (word 18) counts entries taken by the engine. The RX monitor (word 19) counts every byte pushed by the engine, including bytes dropped at a full FIFO. An `eng_start` pulse returns both monitors to 0.
- R11: In reset word 13, writing bit 2 empties the TX FIFO and writing bit 1 empties the RX FIFO; both bits read as 0. Writing bit 0 raises `eng_rst_req` and bit 0 of word 13. Both stay high until `eng_rst_ack`.
- R12: `bus_rdata` is loaded on the clock edge where `bus_rd` is high, and holds its value between reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 5 | Word index within the register window |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| irq_o | output | 1 | Interrupt request |
| eng_tx_valid | output | 1 | TX FIFO holds an entry |
| eng_tx_data | output | 9 | Oldest TX entry |
| eng_tx_take | input | 1 | Engine consumes the TX entry |
| eng_rx_push | input | 1 | Engine delivers a received byte |
| eng_rx_data | input | 8 | Received byte |
| eng_start | input | 1 | Pulse: START condition issued |
| eng_active | input | 1 | Transfer in progress |
| eng_no_ack | input | 1 | Pulse: no acknowledge seen |
| eng_arb_lost | input | 1 | Pulse: arbitration lost |
| eng_dev_busy | input | 1 | Engine busy level |
| eng_bus_busy | input | 1 | Bus busy level |
| eng_bus_mon | input | 4 | Raw bus line levels |
| eng_rst_req | output | 1 | Forced reset request |
| eng_rst_ack | input | 1 | Forced reset completed |
| cfg_ctrl | output | 4 | Control word |
| cfg_slave | output | SLVW | Slave address |
| cfg_cycle | output | TIMW | SCL cycle length |
| cfg_low | output | TIMW | SCL low time |
| cfg_rs_setup | output | TIMW | Restart/stop setup time |
| cfg_dat_setup | output | TIMW | Data setup time |
| cfg_noise | output | 8 | Noise filter setting |
| cfg_tx_count | output | CNTW | TX byte count setting |
| cfg_rx_count | output | CNTW | RX byte count setting |
| cfg_busrst | output | 2 | Bus reset control |

## Verification
Random write and readback traffic over the configuration words separates a wrong offset decode or a wrong stored width from correct storage. Probes of unused words then show whether they alias a real register. The FIFOs are filled past their depth and drained in order, which separates dropped overflow entries from entries that overwrite stored ones. An empty pop shows whether an empty read returns 0. The engine events are tried with the enable on and off, with a clear in the same cycle as a new event, with RX counts of zero and three, and with a TX drain both inside and outside an active transfer. Each case separates a flag that is sticky and gated correctly from one that is set too early, too often, or without the required condition.

// File: rtl/i2cf_pkg.sv
package i2cf_pkg;
   // word indices inside the register window
   localparam logic [4:0] W_CTRL  = 5'd0;
   localparam logic [4:0] W_DATA  = 5'd1;
   localparam logic [4:0] W_SLV   = 5'd3;
   localparam logic [4:0] W_CYC   = 5'd4;
   localparam logic [4:0] W_LOW   = 5'd5;
   localparam logic [4:0] W_RSU   = 5'd6;
   localparam logic [4:0] W_DSU   = 5'd7;
   localparam logic [4:0] W_IST   = 5'd8;
   localparam logic [4:0] W_IEN   = 5'd9;
   localparam logic [4:0] W_ICL   = 5'd10;
   localparam logic [4:0] W_STAT  = 5'd11;
   localparam logic [4:0] W_RST   = 5'd13;
   localparam logic [4:0] W_BMON  = 5'd14;
   localparam logic [4:0] W_NOISE = 5'd15;
   localparam logic [4:0] W_TXC   = 5'd16;
   localparam logic [4:0] W_RXC   = 5'd17;
   localparam logic [4:0] W_TXM   = 5'd18;
   localparam logic [4:0] W_RXM   = 5'd19;
   localparam logic [4:0] W_BRST  = 5'd20;

   // interrupt flag positions
   localparam int IRQ_TXE  = 9;
   localparam int IRQ_RXC  = 4;
   localparam int IRQ_NACK = 2;
   localparam int IRQ_ARB  = 1;
   localparam logic [31:0] IRQ_MASK = 32'h0000_0216;
endpackage

// File: rtl/i2cf_fifo.sv
module i2cf_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 8,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          push,
   input  logic [W-1:0]  wdata,
   input  logic          pop,
   output logic [W-1:0]  rdata,
   output logic          full,
   output logic          empty
);
   logic [CW-1:0] cnt_q;
   logic          do_push, do_pop;

   generate
      if (DEPTH < 1 || (DEPTH > 1 && (DEPTH & (DEPTH - 1)) != 0)) begin : g_bad_depth
         $error("i2cf_fifo: DEPTH must be 1 or a power of two");
      end
   endgenerate

   assign full    = (cnt_q == CW'(DEPTH));
   assign empty   = (cnt_q == '0);
   assign do_push = push && !full && !flush;
   assign do_pop  = pop && !empty && !flush;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt_q <= '0;
      else if (flush) cnt_q <= '0;
      else            cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
   end

   generate
      if (DEPTH == 1) begin : g_single
         logic [W-1:0] d_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       d_q <= '0;
            else if (do_push) d_q <= wdata;
         end
         assign rdata = d_q;
      end else begin : g_ring
         localparam int PW = $clog2(DEPTH);
         logic [W-1:0]  mem_q [DEPTH];
         logic [PW-1:0] rp_q, wp_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               rp_q <= '0;
               wp_q <= '0;
            end else if (flush) begin
               rp_q <= '0;
               wp_q <= '0;
            end else begin
               if (do_push) wp_q <= wp_q + PW'(1);
               if (do_pop)  rp_q <= rp_q + PW'(1);
            end
         end
         always_ff @(posedge clk) begin
            if (do_push) mem_q[wp_q] <= wdata;
         end
         assign rdata = mem_q[rp_q];
      end
   endgenerate

   AST_FIFO_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop && !flush) |=> full); // R3
   AST_FIFO_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && empty && !push && !flush) |=> empty); // R4
endmodule

// File: rtl/i2cf_irq.sv
module i2cf_irq
   import i2cf_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic [31:0] set_i,
   input  logic [31:0] clr_i,
   input  logic [31:0] en_i,
   output logic [31:0] st_o,
   output logic        irq_o
);
   logic [31:0] st_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= '0;
      else        st_q <= ((st_q & ~clr_i) | set_i) & IRQ_MASK;
   end

   assign st_o  = st_q;
   assign irq_o = |(st_q & en_i);

   AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((st_q & $past(st_q & ~clr_i)) == $past(st_q & ~clr_i))); // R6
   AST_IRQ_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((st_q & $past(set_i & IRQ_MASK)) == $past(set_i & IRQ_MASK))); // R6
endmodule

// File: rtl/i2cf_regs.sv
module i2cf_regs
   import i2cf_pkg::*;
#(
   parameter int FIFO_DEPTH = 8,
   parameter int TIMW       = 16,
   parameter int CNTW       = 16,
   parameter int SLVW       = 10
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [4:0]      bus_addr,
   input  logic            bus_wr,
   input  logic            bus_rd,
   input  logic [31:0]     bus_wdata,
   output logic [31:0]     bus_rdata,
   output logic            irq_o,
   output logic            eng_tx_valid,
   output logic [8:0]      eng_tx_data,
   input  logic            eng_tx_take,
   input  logic            eng_rx_push,
   input  logic [7:0]      eng_rx_data,
   input  logic            eng_start,
   input  logic            eng_active,
   input  logic            eng_no_ack,
   input  logic            eng_arb_lost,
   input  logic            eng_dev_busy,
   input  logic            eng_bus_busy,
   input  logic [3:0]      eng_bus_mon,
   output logic            eng_rst_req,
   input  logic            eng_rst_ack,
   output logic [3:0]      cfg_ctrl,
   output logic [SLVW-1:0] cfg_slave,
   output logic [TIMW-1:0] cfg_cycle,
   output logic [TIMW-1:0] cfg_low,
   output logic [TIMW-1:0] cfg_rs_setup,
   output logic [TIMW-1:0] cfg_dat_setup,
   output logic [7:0]      cfg_noise,
   output logic [CNTW-1:0] cfg_tx_count,
   output logic [CNTW-1:0] cfg_rx_count,
   output logic [1:0]      cfg_busrst
);
   generate
      if (TIMW < 1 || TIMW > 32 || CNTW < 1 || CNTW > 32 || SLVW < 1 || SLVW > 32) begin : g_bad_width
         $error("i2cf_regs: register widths must lie in 1..32");
      end
   endgenerate

   logic [3:0]      ctrl_q;
   logic [SLVW-1:0] slv_q;
   logic [TIMW-1:0] cyc_q, low_q, rsu_q, dsu_q;
   logic [7:0]      noise_q;
   logic [CNTW-1:0] txc_q, rxc_q, tx_mon_q, rx_mon_q;
   logic [1:0]      brst_q;
   logic [31:0]     ien_q, ist, ev_set, ev_clr, rd_mux;
   logic            rst_pend_q, tx_empty_q;
   logic            tx_full, tx_empty, rx_full, rx_empty;
   logic            tx_flush, rx_flush, tx_push, rx_pop, tx_taken, rb_hit;
   logic [7:0]      rx_head;

   assign tx_push  = bus_wr && (bus_addr == W_DATA);
   assign rx_pop   = bus_rd && (bus_addr == W_DATA);
   assign tx_flush = bus_wr && (bus_addr == W_RST) && bus_wdata[2];
   assign rx_flush = bus_wr && (bus_addr == W_RST) && bus_wdata[1];
   assign tx_taken = eng_tx_take && !tx_empty;

   i2cf_fifo #(.W(9), .DEPTH(FIFO_DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n), .flush(tx_flush),
      .push(tx_push), .wdata(bus_wdata[8:0]),
      .pop(eng_tx_take), .rdata(eng_tx_data),
      .full(tx_full), .empty(tx_empty));

   i2cf_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_rxq (
      .clk(clk), .rst_n(rst_n), .flush(rx_flush),
      .push(eng_rx_push), .wdata(eng_rx_data),
      .pop(rx_pop), .rdata(rx_head),
      .full(rx_full), .empty(rx_empty));

   assign eng_tx_valid = !tx_empty;

   // configuration and bookkeeping registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0; slv_q <= '0; cyc_q <= '0; low_q <= '0;
         rsu_q <= '0; dsu_q <= '0; noise_q <= '0; txc_q <= '0;
         rxc_q <= '0; brst_q <= '0; ien_q <= '0;
         rst_pend_q <= 1'b0; tx_mon_q <= '0; rx_mon_q <= '0;
         tx_empty_q <= 1'b1;
      end else begin
         if (bus_wr) begin
            case (bus_addr)
               W_CTRL:  ctrl_q  <= bus_wdata[3:0];
               W_SLV:   slv_q   <= bus_wdata[SLVW-1:0];
               W_CYC:   cyc_q   <= bus_wdata[TIMW-1:0];
               W_LOW:   low_q   <= bus_wdata[TIMW-1:0];
               W_RSU:   rsu_q   <= bus_wdata[TIMW-1:0];
               W_DSU:   dsu_q   <= bus_wdata[TIMW-1:0];
               W_IEN:   ien_q   <= bus_wdata & IRQ_MASK;
               W_NOISE: noise_q <= bus_wdata[7:0];
               W_TXC:   txc_q   <= bus_wdata[CNTW-1:0];
               W_RXC:   rxc_q   <= bus_wdata[CNTW-1:0];
               W_BRST:  brst_q  <= bus_wdata[1:0];
               default: ;
            endcase
         end
         if (bus_wr && (bus_addr == W_RST) && bus_wdata[0]) rst_pend_q <= 1'b1;
         else if (eng_rst_ack)                              rst_pend_q <= 1'b0;
         if (eng_start) begin
            tx_mon_q <= '0;
            rx_mon_q <= '0;
         end else begin
            if (tx_taken)    tx_mon_q <= tx_mon_q + CNTW'(1);
            if (eng_rx_push) rx_mon_q <= rx_mon_q + CNTW'(1);
         end
         tx_empty_q <= tx_empty;
      end
   end

   assign rb_hit = eng_rx_push && !eng_start &&
                   ((rxc_q == '0) || ((rx_mon_q + CNTW'(1)) == rxc_q));

   always_comb begin
      ev_set           = '0;
      ev_set[IRQ_TXE]  = eng_active && tx_empty && !tx_empty_q;
      ev_set[IRQ_RXC]  = rb_hit;
      ev_set[IRQ_NACK] = eng_no_ack;
      ev_set[IRQ_ARB]  = eng_arb_lost;
      ev_clr           = (bus_wr && (bus_addr == W_ICL)) ? bus_wdata : '0;
   end

   i2cf_irq u_irq (
      .clk(clk), .rst_n(rst_n), .set_i(ev_set), .clr_i(ev_clr),
      .en_i(ien_q), .st_o(ist), .irq_o(irq_o));

   always_comb begin
      case (bus_addr)
         W_CTRL:  rd_mux = 32'(ctrl_q);
         W_DATA:  rd_mux = rx_empty ? 32'h0 : 32'(rx_head);
         W_SLV:   rd_mux = 32'(slv_q);
         W_CYC:   rd_mux = 32'(cyc_q);
         W_LOW:   rd_mux = 32'(low_q);
         W_RSU:   rd_mux = 32'(rsu_q);
         W_DSU:   rd_mux = 32'(dsu_q);
         W_IST:   rd_mux = ist;
         W_IEN:   rd_mux = ien_q;
         W_STAT:  rd_mux = {19'd0, eng_dev_busy, 3'd0, eng_bus_busy, 4'd0,
                             rx_full, !rx_empty, !tx_full, tx_empty};
         W_RST:   rd_mux = {31'd0, rst_pend_q};
         W_BMON:  rd_mux = 32'(eng_bus_mon);
         W_NOISE: rd_mux = 32'(noise_q);
         W_TXC:   rd_mux = 32'(txc_q);
         W_RXC:   rd_mux = 32'(rxc_q);
         W_TXM:   rd_mux = 32'(tx_mon_q);
         W_RXM:   rd_mux = 32'(rx_mon_q);
         W_BRST:  rd_mux = 32'(brst_q);
         default: rd_mux = 32'h0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_rd) bus_rdata <= rd_mux;
   end

   assign eng_rst_req   = rst_pend_q;
   assign cfg_ctrl      = ctrl_q;
   assign cfg_slave     = slv_q;
   assign cfg_cycle     = cyc_q;
   assign cfg_low       = low_q;
   assign cfg_rs_setup  = rsu_q;
   assign cfg_dat_setup = dsu_q;
   assign cfg_noise     = noise_q;
   assign cfg_tx_count  = txc_q;
   assign cfg_rx_count  = rxc_q;
   assign cfg_busrst    = brst_q;

   AST_RST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_rst_req && !eng_rst_ack) |=> eng_rst_req); // R11
   AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && (bus_addr == W_DATA) && rx_empty) |=> (bus_rdata == 32'h0)); // R4
   AST_MON_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start |=> ((tx_mon_q == '0) && (rx_mon_q == '0))); // R10
   AST_NACK_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_no_ack && ien_q[IRQ_NACK]) |=> irq_o); // R7
   AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> $stable(bus_rdata)); // R12
endmodule

// File: tb/i2cf_regs_tb_top.sv
module i2cf_regs_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH = 8;
   localparam logic [4:0] A_CTRL = 5'd0, A_DATA = 5'd1, A_SLV = 5'd3, A_CYC = 5'd4,
      A_LOW = 5'd5, A_RSU = 5'd6, A_DSU = 5'd7, A_IST = 5'd8, A_IEN = 5'd9,
      A_ICL = 5'd10, A_STAT = 5'd11, A_RST = 5'd13, A_BMON = 5'd14, A_NOISE = 5'd15,
      A_TXC = 5'd16, A_RXC = 5'd17, A_TXM = 5'd18, A_RXM = 5'd19, A_BRST = 5'd20;

   logic clk = 1'b0, rst_n = 1'b0;
   logic [4:0] bus_addr = '0;
   logic bus_wr = 1'b0, bus_rd = 1'b0;
   logic [31:0] bus_wdata = '0, bus_rdata;
   logic irq_o, eng_tx_valid, eng_rst_req;
   logic [8:0] eng_tx_data;
   logic eng_tx_take = 1'b0, eng_rx_push = 1'b0, eng_start = 1'b0, eng_active = 1'b0;
   logic eng_no_ack = 1'b0, eng_arb_lost = 1'b0, eng_dev_busy = 1'b0, eng_bus_busy = 1'b0;
   logic eng_rst_ack = 1'b0;
   logic [7:0] eng_rx_data = '0;
   logic [3:0] eng_bus_mon = '0;
   logic [3:0] cfg_ctrl;
   logic [9:0] cfg_slave;
   logic [15:0] cfg_cycle, cfg_low, cfg_rs_setup, cfg_dat_setup, cfg_tx_count, cfg_rx_count;
   logic [7:0] cfg_noise;
   logic [1:0] cfg_busrst;

   int n_chk = 0, n_bad = 0;
   logic [31:0] shadow [32];
   logic [8:0]  txq [DEPTH+1];
   logic [7:0]  rxq [DEPTH+2];
   logic [31:0] rd;

   always #(CLK_PERIOD/2) clk = ~clk;

   i2cf_regs #(.FIFO_DEPTH(DEPTH)) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o),
      .eng_tx_valid(eng_tx_valid), .eng_tx_data(eng_tx_data), .eng_tx_take(eng_tx_take),
      .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data), .eng_start(eng_start),
      .eng_active(eng_active), .eng_no_ack(eng_no_ack), .eng_arb_lost(eng_arb_lost),
      .eng_dev_busy(eng_dev_busy), .eng_bus_busy(eng_bus_busy), .eng_bus_mon(eng_bus_mon),
      .eng_rst_req(eng_rst_req), .eng_rst_ack(eng_rst_ack),
      .cfg_ctrl(cfg_ctrl), .cfg_slave(cfg_slave), .cfg_cycle(cfg_cycle), .cfg_low(cfg_low),
      .cfg_rs_setup(cfg_rs_setup), .cfg_dat_setup(cfg_dat_setup), .cfg_noise(cfg_noise),
      .cfg_tx_count(cfg_tx_count), .cfg_rx_count(cfg_rx_count), .cfg_busrst(cfg_busrst));

   function automatic logic [31:0] width_mask(input logic [4:0] w);
      case (w)
         A_CTRL:  return 32'hF;
         A_SLV:   return 32'h3FF;
         A_CYC, A_LOW, A_RSU, A_DSU, A_TXC, A_RXC: return 32'hFFFF;
         A_IEN:   return 32'h216;
         A_NOISE: return 32'hFF;
         A_BRST:  return 32'h3;
         default: return 32'h0;
      endcase
   endfunction

   function automatic logic [4:0] pick_rw(input int k);
      case (k)
         0: return A_CTRL;  1: return A_SLV;  2: return A_CYC;  3: return A_LOW;
         4: return A_RSU;   5: return A_DSU;  6: return A_IEN;  7: return A_NOISE;
         8: return A_TXC;   9: return A_RXC;  default: return A_BRST;
      endcase
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bwr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk); bus_wr = 1'b0;
      shadow[a] = d & width_mask(a);
   endtask

   task automatic brd(input logic [4:0] a, output logic [31:0] d);
      @(negedge clk); bus_addr = a; bus_rd = 1'b1;
      @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
   endtask

   task automatic rx_byte(input logic [7:0] b);
      @(negedge clk); eng_rx_push = 1'b1; eng_rx_data = b;
      @(negedge clk); eng_rx_push = 1'b0;
   endtask

   task automatic tx_take;
      @(negedge clk); eng_tx_take = 1'b1;
      @(negedge clk); eng_tx_take = 1'b0;
   endtask

   task automatic start_pulse;
      @(negedge clk); eng_start = 1'b1;
      @(negedge clk); eng_start = 1'b0;
   endtask

   task automatic finish_run;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not complete actual=hung expected=done");
      finish_run();
   end

   initial begin
      void'($urandom(32'd1234));
      for (int i = 0; i < 32; i++) shadow[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // reset state
      brd(A_STAT, rd); check("R5 reset status", rd, 32'h3);
      check("R7 reset irq", {31'd0, irq_o}, 32'h0);
      brd(A_DATA, rd); check("R4 empty read after reset", rd, 32'h0);

      // random configuration traffic
      for (int i = 0; i < 200; i++) begin
         logic [4:0] a;
         a = pick_rw(int'($urandom_range(0, 10)));
         if ($urandom_range(0, 1) == 0) bwr(a, $urandom());
         else begin
            brd(a, rd); check("R1 readback", rd, shadow[a]);
         end
      end
      check("R1 cfg_cycle output", 32'(cfg_cycle), shadow[A_CYC]);
      check("R1 cfg_slave output", 32'(cfg_slave), shadow[A_SLV]);

      // unused words
      bwr(5'd2, 32'hFFFF_FFFF); bwr(5'd12, 32'hFFFF_FFFF); bwr(5'd31, 32'hFFFF_FFFF);
      brd(5'd2, rd);  check("R2 word 2", rd, 32'h0);
      brd(5'd12, rd); check("R2 word 12", rd, 32'h0);
      brd(5'd31, rd); check("R2 word 31", rd, 32'h0);
      brd(A_ICL, rd); check("R2 clear word reads 0", rd, 32'h0);
      for (int k = 0; k < 11; k++) begin
         brd(pick_rw(k), rd); check("R2 no aliasing", rd, shadow[pick_rw(k)]);
      end

      bwr(A_IEN, 32'h0); bwr(A_RXC, 32'h0);
      start_pulse();

      // TX FIFO overflow and drain
      for (int i = 0; i <= DEPTH; i++) begin
         txq[i] = 9'($urandom());
         bwr(A_DATA, {23'd0, txq[i]});
      end
      brd(A_STAT, rd); check("R5 TX full status", rd, 32'h0);
      for (int i = 0; i < DEPTH; i++) begin
         @(negedge clk);
         check("R3 tx valid", {31'd0, eng_tx_valid}, 32'h1);
         check("R3 tx order", {23'd0, eng_tx_data}, {23'd0, txq[i]});
         tx_take();
      end
      check("R3 overflow entry dropped", {31'd0, eng_tx_valid}, 32'h0);
      brd(A_TXM, rd); check("R10 tx monitor", rd, DEPTH);
      brd(A_IST, rd); check("R8 no drain flag when idle", rd, 32'h0);
      start_pulse();
      brd(A_TXM, rd); check("R10 tx monitor cleared", rd, 32'h0);

      // RX FIFO overflow, pops and empty pop
      for (int i = 0; i < DEPTH + 2; i++) begin
         rxq[i] = 8'($urandom());
         rx_byte(rxq[i]);
      end
      brd(A_STAT, rd); check("R5 RX full status", rd, 32'hF);
      brd(A_RXM, rd); check("R10 rx monitor counts drops", rd, DEPTH + 2);
      brd(A_IST, rd); check("R9 count 0 flags every byte", rd, 32'h10);
      for (int i = 0; i < DEPTH; i++) begin
         brd(A_DATA, rd); check("R4 rx order", rd, {24'd0, rxq[i]});
      end
      brd(A_DATA, rd); check("R4 empty pop returns 0", rd, 32'h0);
      brd(A_STAT, rd); check("R4 empty pop leaves FIFO empty", rd, 32'h3);
      bwr(A_ICL, 32'h10);
      brd(A_IST, rd); check("R6 clear rx flag", rd, 32'h0);

      // RX count of three
      bwr(A_RXC, 32'd3);
      start_pulse();
      rx_byte(8'h11); rx_byte(8'h22);
      brd(A_IST, rd); check("R9 not before count", rd, 32'h0);
      rx_byte(8'h33);
      brd(A_IST, rd); check("R9 flag at count", rd, 32'h10);
      brd(A_RXM, rd); check("R10 rx monitor after start", rd, 32'd3);
      bwr(A_RST, 32'h2);
      brd(A_STAT, rd); check("R11 RX flush", rd, 32'h3);
      brd(A_RST, rd); check("R11 flush bits read 0", rd, 32'h0);
      bwr(A_ICL, 32'hFFFF_FFFF);

      // interrupt enable, sticky flags, ignored writes, set wins
      bwr(A_IEN, 32'h4);
      @(negedge clk); eng_no_ack = 1'b1;
      @(negedge clk); eng_no_ack = 1'b0;
      check("R7 irq on enabled flag", {31'd0, irq_o}, 32'h1);
      repeat (3) @(negedge clk);
      check("R6 flag sticky", {31'd0, irq_o}, 32'h1);
      bwr(A_IST, 32'h0);
      brd(A_IST, rd); check("R6 status write ignored", rd, 32'h4);
      bwr(A_ICL, 32'h4);
      check("R7 irq drops after clear", {31'd0, irq_o}, 32'h0);
      @(negedge clk); eng_arb_lost = 1'b1;
      @(negedge clk); eng_arb_lost = 1'b0;
      check("R7 masked flag no irq", {31'd0, irq_o}, 32'h0);
      @(negedge clk); bus_addr = A_ICL; bus_wdata = 32'h2; bus_wr = 1'b1; eng_arb_lost = 1'b1;
      @(negedge clk); bus_wr = 1'b0; eng_arb_lost = 1'b0;
      brd(A_IST, rd); check("R6 set wins over clear", rd, 32'h2);
      bwr(A_ICL, 32'hFFFF_FFFF);
      bwr(A_IEN, 32'h0);

      // TX drained flag
      eng_active = 1'b1;
      bwr(A_DATA, 32'h1A5);
      tx_take();
      @(negedge clk);
      brd(A_IST, rd); check("R8 drain while active", rd, 32'h200);
      bwr(A_ICL, 32'h200);
      eng_active = 1'b0;
      bwr(A_DATA, 32'h05A);
      tx_take();
      @(negedge clk);
      brd(A_IST, rd); check("R8 no flag when inactive", rd, 32'h0);

      // status levels and bus monitor
      eng_dev_busy = 1'b1; eng_bus_busy = 1'b1; eng_bus_mon = 4'hA;
      brd(A_STAT, rd); check("R5 busy bits", rd, 32'h1103);
      brd(A_BMON, rd); check("R5 bus monitor", rd, 32'hA);
      eng_dev_busy = 1'b0; eng_bus_busy = 1'b0;

      // forced reset handshake
      bwr(A_RST, 32'h1);
      check("R11 reset request raised", {31'd0, eng_rst_req}, 32'h1);
      repeat (4) @(negedge clk);
      brd(A_RST, rd); check("R11 reset bit held", rd, 32'h1);
      @(negedge clk); eng_rst_ack = 1'b1;
      @(negedge clk); eng_rst_ack = 1'b0;
      brd(A_RST, rd); check("R11 reset bit after ack", rd, 32'h0);
      check("R11 request dropped", {31'd0, eng_rst_req}, 32'h0);

      // TX flush
      bwr(A_DATA, 32'h011); bwr(A_DATA, 32'h022);
      bwr(A_RST, 32'h4);
      check("R11 TX flush", {31'd0, eng_tx_valid}, 32'h0);
      brd(A_STAT, rd); check("R11 status after TX flush", rd, 32'h3);

      // read data holds between reads
      brd(A_CYC, rd);
      repeat (3) @(negedge clk);
      check("R12 rdata holds", bus_rdata, shadow[A_CYC]);

      finish_run();
   end
endmodule